// File: doc/BRIEF.md
# Polyphase Interpolate-by-Four FIR Filter

This block raises the sample rate of a signed data stream by a factor of four and applies a 16-tap low-pass FIR filter to the result. The filter works as if three zeros were inserted after every input sample and the 16-tap convolution were then computed at the fast rate. Most of the taps would see zeros, so the block never inserts them. Instead, one bank of four multipliers and an adder tree is shared across the four polyphase branches. On every enabled fast-clock cycle, a phase counter rotates which group of four coefficients is fed into that datapath. The same four stored samples are used for all four phases.

The core runs entirely on the fast clock. The slow input rate is produced inside the block: it accepts one sample every fourth enabled cycle. A ready strobe tells the upstream logic in which cycle the data port is sampled. The clock enable stalls the whole pipeline, including the phase counter. The coefficients are a constant parameter table held in small per-branch ROMs with a registered read. One filtered sample leaves the block on every enabled cycle once the pipeline has filled.

Top module: `poly_interp4_fir`

## Requirements
- R1: While reset is high and after its release, `dout` is 0, `dout_vld` is 0 and `din_ready` is 1, before any further enabled cycle occurs.
- R2: `din_ready` is 1 exactly when the number of enabled cycles since reset, counted modulo 4, is 0. It is therefore high for one enabled cycle in four, and it is high on the first enabled cycle after reset.
- R3: `din` is captured only on an enabled cycle in which `din_ready` is 1. Values on `din` in every other cycle have no effect on any output.
- R4: Let x[m] be the m-th captured sample, and let u[4m] = x[m] with all other u values 0. Output sample n equals y[n] = sum over k = 0..15 of h[k]*u[n-k], at full precision.
- R5: The coefficients rotate in a fixed order. Output 4m+p (p = 0..3) is formed from h[p], h[p+4], h[p+8] and h[p+12], applied to x[m], x[m-1], x[m-2] and x[m-3] in that order. A single captured 1 therefore reproduces h[0] through h[15] in order.
- R6: Output sample n appears on `dout` after enabled cycle n+2 since reset, counting from 1. `dout_vld` rises after the second enabled cycle and stays high until the next reset. Before that point `dout` is 0.
- R7: While `clk_en` is 0, `dout`, `dout_vld`, `din_ready` and all internal state hold their values.
- R8: With the default widths (18-bit samples, 6-bit coefficients), every sum of four products, including full-scale negative samples times the most negative coefficient, appears on the 26-bit `dout` with no overflow or wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast (output-rate) clock |
| rst | input | 1 | Synchronous active-high reset, takes effect regardless of `clk_en` |
| clk_en | input | 1 | Clock enable; when low, all state holds |
| din | input | 18 | Signed input sample, sampled when `clk_en` and `din_ready` are both 1 |
| din_ready | output | 1 | High in the cycle where the next input sample will be taken |
| dout | output | 26 | Signed filtered output at four times the input rate |
| dout_vld | output | 1 | High once the pipeline has filled after reset |

## Verification
The bench builds the block at its default sizes: interpolation factor 4, 16 taps, 18-bit samples, 6-bit coefficients and a 26-bit output. It supplies its own coefficient table, which mixes both extreme 6-bit values, a zero and asymmetric signs, so that any misplaced tap index, swapped branch or lost sign changes some output. At these sizes, every output of every run can be compared against a zero-stuffed convolution computed in the bench. The runs cover an impulse, random streams with noise on the ignored input cycles, random clock-enable gaps, resets under both enable levels, and full-scale alternating inputs that reach the extremes of the accumulator.

// File: rtl/pif_pkg.sv
package pif_pkg;

  // Width of a lossless sum of `terms` products of dw x cw signed operands.
  function automatic int unsigned sop_width(int unsigned dw, int unsigned cw, int unsigned terms);
    int unsigned g;
    g = (terms > 1) ? $clog2(terms) : 0;
    return dw + cw + g;
  endfunction

  // Width of a counter over `n` states, never below one bit.
  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pif_phase_ctrl.sv
module pif_phase_ctrl #(
  parameter int unsigned FACTOR = 4,
  parameter int unsigned PH_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  output logic [PH_W-1:0] phase,
  output logic            at_zero
);

  localparam logic [PH_W-1:0] LAST = PH_W'(FACTOR - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (en) begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assign phase   = phase_q;
  assign at_zero = (phase_q == '0);

  // R2: after the last phase the counter returns to the accept phase
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (en && phase_q == LAST) |=> at_zero);

  // R5: phases advance one step per enabled cycle
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (en && phase_q != LAST) |=> (phase_q == $past(phase_q) + 1'b1));

  // R7: a stalled cycle leaves the phase untouched
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phase_q));

endmodule

// File: rtl/pif_tap_line.sv
module pif_tap_line #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic                          load,
  input  logic [DATA_W-1:0]             din,
  output logic [DEPTH-1:0][DATA_W-1:0]  taps
);

  logic [DEPTH-1:0][DATA_W-1:0] line_q;

  // Index 0 holds the newest sample; older samples move toward DEPTH-1.
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
    end else if (en && load) begin
      line_q <= {line_q[DEPTH-2:0], din};
    end
  end

  assign taps = line_q;

  // R3: an accepted sample lands in the newest slot
  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (en && load) |=> (line_q[0] == $past(din)));

  // R3: without an accept, the stored samples do not move
  p_ignore_r3: assert property (@(posedge clk) disable iff (rst)
    !(en && load) |=> $stable(line_q));

endmodule

// File: rtl/pif_coef_bank.sv
module pif_coef_bank #(
  parameter int unsigned COEF_W = 6,
  parameter int unsigned FACTOR = 4,
  parameter int unsigned BR     = 4,
  parameter int unsigned TAPS   = 16,
  parameter int unsigned PH_W   = 2,
  parameter int          COEF [TAPS] = '{default: 0}
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic [PH_W-1:0]              phase,
  output logic [BR-1:0][COEF_W-1:0]    coef
);

  logic [BR-1:0][COEF_W-1:0] coef_q;

  // One small ROM per delay-line position; each holds that position's
  // coefficient for every phase, read through a register.
  for (genvar j = 0; j < BR; j++) begin : g_branch
    logic [COEF_W-1:0] rom [FACTOR];

    for (genvar p = 0; p < FACTOR; p++) begin : g_word
      assign rom[p] = COEF_W'(COEF[j*FACTOR + p]);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        coef_q[j] <= '0;
      end else if (en) begin
        coef_q[j] <= rom[phase];
      end
    end
  end

  assign coef = coef_q;

  // R7: the coefficient registers hold across a stall
  p_coef_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(coef_q));

endmodule

// File: rtl/pif_mac.sv
module pif_mac #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned COEF_W = 6,
  parameter int unsigned BR     = 4,
  parameter int unsigned OUT_W  = 26
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic [BR-1:0][DATA_W-1:0]     taps,
  input  logic [BR-1:0][COEF_W-1:0]     coef,
  output logic [OUT_W-1:0]              sum
);

  localparam int unsigned PW = DATA_W + COEF_W;
  localparam int unsigned FW = pif_pkg::sop_width(DATA_W, COEF_W, BR);
  localparam int unsigned SW = FW + 1;

  logic signed [PW-1:0]    prod [BR];
  logic signed [SW-1:0]    acc;
  logic signed [OUT_W-1:0] acc_fit;
  logic [OUT_W-1:0]        sum_q;

  for (genvar j = 0; j < BR; j++) begin : g_mul
    assign prod[j] = $signed(taps[j]) * $signed(coef[j]);
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < BR; j++) begin
      acc = acc + SW'(prod[j]);
    end
  end

  assign acc_fit = OUT_W'(acc);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
    end else if (en) begin
      sum_q <= acc_fit;
    end
  end

  assign sum = sum_q;

  // R8: when the output is narrower than the guarded sum, the registered
  // result must still equal the exact sum of products
  if (OUT_W < SW) begin : g_narrow
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
      en |=> (SW'($signed(sum_q)) == $past(acc)));
  end

endmodule

// File: rtl/poly_interp4_fir.sv
module poly_interp4_fir #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned COEF_W = 6,
  parameter int unsigned OUT_W  = 26,
  parameter int unsigned TAPS   = 16,
  parameter int unsigned FACTOR = 4,
  parameter int          COEF [TAPS] = '{-1, -2, -3, 2, 9, 18, 27, 31,
                                         31, 27, 18, 9, 2, -3, -2, -1}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clk_en,
  input  logic [DATA_W-1:0]        din,
  output logic                     din_ready,
  output logic [OUT_W-1:0]         dout,
  output logic                     dout_vld
);

  localparam int unsigned BR   = TAPS / FACTOR;
  localparam int unsigned PH_W = pif_pkg::idx_width(FACTOR);

  logic [PH_W-1:0]               phase;
  logic                          accept_slot;
  logic [BR-1:0][DATA_W-1:0]     taps;
  logic [BR-1:0][COEF_W-1:0]     coef;
  logic [OUT_W-1:0]              sum;
  logic                          fill_q;
  logic                          vld_q;

  pif_phase_ctrl #(
    .FACTOR (FACTOR),
    .PH_W   (PH_W)
  ) u_phase (
    .clk     (clk),
    .rst     (rst),
    .en      (clk_en),
    .phase   (phase),
    .at_zero (accept_slot)
  );

  pif_tap_line #(
    .DATA_W (DATA_W),
    .DEPTH  (BR)
  ) u_line (
    .clk  (clk),
    .rst  (rst),
    .en   (clk_en),
    .load (accept_slot),
    .din  (din),
    .taps (taps)
  );

  pif_coef_bank #(
    .COEF_W (COEF_W),
    .FACTOR (FACTOR),
    .BR     (BR),
    .TAPS   (TAPS),
    .PH_W   (PH_W),
    .COEF   (COEF)
  ) u_coef (
    .clk   (clk),
    .rst   (rst),
    .en    (clk_en),
    .phase (phase),
    .coef  (coef)
  );

  pif_mac #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .BR     (BR),
    .OUT_W  (OUT_W)
  ) u_mac (
    .clk  (clk),
    .rst  (rst),
    .en   (clk_en),
    .taps (taps),
    .coef (coef),
    .sum  (sum)
  );

  // Two enabled cycles fill the pipe: coefficient/sample registers, then sum.
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (clk_en) begin
      fill_q <= 1'b1;
      vld_q  <= fill_q;
    end
  end

  assign din_ready = accept_slot;
  assign dout      = sum;
  assign dout_vld  = vld_q;

  // R6: once valid, the output stays valid until reset
  p_vld_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    dout_vld |=> dout_vld);

  // R2: an accepted slot is never followed directly by another
  p_one_slot_r2: assert property (@(posedge clk) disable iff (rst)
    (clk_en && din_ready) |=> !din_ready);

  // R7: outputs freeze while the enable is low
  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(dout) && $stable(dout_vld) && $stable(din_ready)));

endmodule

// File: tb/poly_interp4_fir_tb_top.sv
module poly_interp4_fir_tb_top;

  localparam int DW = 18;
  localparam int CW = 6;
  localparam int OW = 26;
  localparam int NT = 16;
  localparam int NX = 512;
  localparam int H [NT] = '{31, -32, 5, -7, 1, 2, -3, 4,
                            -32, 31, -1, 0, 17, -9, 11, -20};
  localparam longint XMAX = 131071;
  localparam longint XMIN = -131072;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic          clk_en;
  logic [DW-1:0] din;
  logic          din_ready;
  logic [OW-1:0] dout;
  logic          dout_vld;

  poly_interp4_fir #(
    .DATA_W (DW),
    .COEF_W (CW),
    .OUT_W  (OW),
    .TAPS   (NT),
    .FACTOR (4),
    .COEF   (H)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .din       (din),
    .din_ready (din_ready),
    .dout      (dout),
    .dout_vld  (dout_vld)
  );

  int     n_chk = 0;
  int     n_bad = 0;
  bit     done  = 1'b0;
  longint xs [NX];
  int     en_cnt;

  function automatic longint exp_y(int n);
    longint s = 0;
    int m = n / 4;
    int p = n % 4;
    for (int j = 0; j < 4; j++) begin
      if (m - j >= 0 && m - j < NX) s += longint'(H[4*j + p]) * xs[m - j];
    end
    return s;
  endfunction

  function automatic longint rnd();
    logic signed [DW-1:0] r;
    r = DW'($urandom);
    return longint'(r);
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    en_cnt = 0;
    for (int i = 0; i < NX; i++) xs[i] = 0;
  endtask

  task automatic check_outputs(input string tag);
    check("R2 ready", longint'(din_ready), longint'(en_cnt % 4 == 0));
    check("R6 valid", longint'(dout_vld), longint'(en_cnt >= 2));
    check(tag, longint'($signed(dout)), (en_cnt >= 2) ? exp_y(en_cnt - 2) : 0);
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic cyc(input bit en, input longint x, input string tag);
    clk_en = en;
    din    = x[DW-1:0];
    @(posedge clk);
    if (en) begin
      if (en_cnt % 4 == 0 && en_cnt / 4 < NX) xs[en_cnt / 4] = x;
      en_cnt++;
    end
    @(negedge clk);
    check_outputs(en ? tag : "R7 hold");
  endtask

  task automatic do_reset(input bit en_during);
    rst    = 1'b1;
    clk_en = en_during;
    din    = DW'($urandom);
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
    end
    check("R1 dout in reset", longint'($signed(dout)), 0);
    rst = 1'b0;
    clear_model();
    check("R1 dout", longint'($signed(dout)), 0);
    check("R1 valid", longint'(dout_vld), 0);
    check("R1 ready", longint'(din_ready), 1);
  endtask

  initial begin
    rst    = 1'b1;
    clk_en = 1'b0;
    din    = '0;
    clear_model();
    @(negedge clk);

    // R1, R5: impulse reproduces the coefficient table in order
    do_reset(1'b1);
    for (int c = 0; c < 80; c++) cyc(1'b1, (c == 0) ? 1 : 0, "R5 impulse");

    // R3: noise on non-accept cycles must not reach the output
    do_reset(1'b0);
    for (int c = 0; c < 160; c++) cyc(1'b1, rnd(), "R3 ignored input");

    // R4, R7: random data under random enable gaps and a long stall
    do_reset(1'b1);
    for (int c = 0; c < 300; c++) begin
      cyc(($urandom % 4) != 0, rnd(), "R4 convolution");
      if (c == 150) begin
        for (int s = 0; s < 12; s++) cyc(1'b0, rnd(), "R7 stall");
      end
    end

    // R8: full-scale inputs, reset taken while the pipe is busy
    do_reset(1'b1);
    for (int c = 0; c < 200; c++) begin
      longint xv;
      case ((c / 4) % 4)
        0: xv = XMIN;
        1: xv = XMAX;
        2: xv = XMIN;
        default: xv = (c % 8 < 4) ? XMAX : XMIN;
      endcase
      cyc((c % 11) != 10, xv, "R8 full scale");
    end
    for (int c = 0; c < 60; c++) cyc(1'b1, XMIN, "R8 negative run");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule